// File: doc/BRIEF.md
# Fully Associative Translation Buffer Fill Store

This block holds the entries of a fully associative address translation buffer and the small register bank that software-visible logic uses to load and inspect it. Each of the 64 entries pairs a 64-bit tag with a 64-bit data word. In the data word, bit 63 marks the entry valid and bit 6 marks it locked. The store performs no translation of its own. It is the part that a translation pipeline would look up, and it is filled and examined through a single-cycle request bus.

A request carries an operation code, an address and a write word. The address picks a control register through bits [6:3], or an entry slot through bits [8:3]. An automatic fill chooses its own victim. It takes the lowest-numbered invalid entry first. If every entry is valid, it takes the lowest-numbered unlocked entry. If every entry is both valid and locked, the fill is dropped and a one-cycle flag is raised. Every entry write takes its tag from the tag-staging control register (index 6) and its data from the write word. A search operation compares a key against the tags of valid entries. Read-type operations answer one cycle after the request.

Top module: `tlbf_store`

## Requirements
- R1: After reset every entry is invalid, every control register reads zero, and `rsp_valid` and `fill_dropped` are low.
- R2: An automatic fill (op 2) while any entry has bit 63 clear writes the lowest-indexed such entry.
- R3: An automatic fill while all entries are valid writes the lowest-indexed entry whose data bit 6 is clear.
- R4: An automatic fill while all entries are valid and locked changes no entry, and raises `fill_dropped` for exactly the cycle after the request.
- R5: Every entry write, whether automatic or indexed, stores control register 6 as the tag and `req_wdata` as the data.
- R6: An indexed entry write (op 3) writes the entry numbered by `req_addr[8:3]`.
- R7: A tag search (op 4) with key `req_wdata` returns the tag of a valid entry whose tag equals the key. If there is no valid match, it returns zero, even when an invalid entry holds that tag.
- R8: Control register write (op 1) and read (op 0) select the register with `req_addr[6:3]`. The other address bits do not affect the selection, and each register holds its own value.
- R9: A write to control register 3 with bit 0 clear sets registers 3 and 4 to zero. With bit 0 set, the write stores the word in register 3.
- R10: `rsp_valid` is high in the cycle after an op 0, 4 or 5 request and low otherwise. Ops 6 and 7 change nothing.
- R11: An entry data read (op 5) returns the data word of the entry numbered by `req_addr[8:3]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation: 0 reg read, 1 reg write, 2 auto fill, 3 indexed write, 4 tag search, 5 data read |
| req_addr | input | 12 | Register select [6:3], entry select [8:3] |
| req_wdata | input | 64 | Write word or search key |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 64 | Read response word |
| fill_dropped | output | 1 | Pulse: automatic fill found no victim |

## Verification
The checks assume that only one request arrives per cycle and that `req_op` is stable while `req_valid` is high. The bench drives requests on falling edges and holds each one for a single clock, so both assumptions hold. The fill-count property depends on the valid bit of the fill word, and it applies only while a free slot exists. The stimulus therefore mixes fills that carry valid words into tables that are partly empty, nearly full and fully locked. That way the invalid-first path, the unlocked fallback and the dropped case are each reached.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;
   typedef enum logic [2:0] {
      OP_CREG_RD  = 3'd0,
      OP_CREG_WR  = 3'd1,
      OP_FILL     = 3'd2,
      OP_SLOT_WR  = 3'd3,
      OP_TAG_SRCH = 3'd4,
      OP_SLOT_RD  = 3'd5
   } tlbf_op_e;

   function automatic logic op_is_read(input logic [2:0] op);
      return (op == OP_CREG_RD) || (op == OP_TAG_SRCH) || (op == OP_SLOT_RD);
   endfunction
endpackage

// File: rtl/tlbf_lowest_one.sv
// Finds the lowest set bit of a vector.
module tlbf_lowest_one #(
   parameter int N = 64
) (
   input  logic [N-1:0]         vec,
   output logic [$clog2(N)-1:0] idx,
   output logic                 found
);
   localparam int IDXW = $clog2(N);

   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx   = IDXW'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/tlbf_ctl_bank.sv
// Control register bank; the status-clear write also zeroes its partner register.
module tlbf_ctl_bank #(
   parameter int NREG    = 16,
   parameter int W       = 64,
   parameter int FSR_REG = 3,
   parameter int FAR_REG = 4,
   parameter int CLR_BIT = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [$clog2(NREG)-1:0] sel,
   input  logic [W-1:0]            wdata,
   output logic [NREG*W-1:0]       regs_flat
);
   localparam int SELW = $clog2(NREG);

   logic status_clear;
   assign status_clear = wr_en && (sel == SELW'(FSR_REG)) && !wdata[CLR_BIT];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [W-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_q <= '0;
         end else if (g == FSR_REG && status_clear) begin
            r_q <= '0;
         end else if (g == FAR_REG && status_clear) begin
            r_q <= '0;
         end else if (wr_en && sel == SELW'(g)) begin
            r_q <= wdata;
         end
      end
      assign regs_flat[g*W +: W] = r_q;
   end
endmodule

// File: rtl/tlbf_entry_array.sv
// Tag and data storage with an indexed write port, a data read port and a tag search.
module tlbf_entry_array #(
   parameter int N         = 64,
   parameter int W         = 64,
   parameter int VALID_BIT = 63,
   parameter int LOCK_BIT  = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [$clog2(N)-1:0] wr_idx,
   input  logic [W-1:0]         wr_tag,
   input  logic [W-1:0]         wr_data,
   input  logic [$clog2(N)-1:0] rd_idx,
   input  logic [W-1:0]         srch_key,
   output logic [N-1:0]         valid_vec,
   output logic [N-1:0]         lock_vec,
   output logic [W-1:0]         rd_data,
   output logic [W-1:0]         srch_tag,
   output logic                 srch_hit
);
   localparam int IDXW = $clog2(N);

   logic [N-1:0][W-1:0] tag_arr;
   logic [N-1:0][W-1:0] data_arr;
   logic [N-1:0]        hit_vec;
   logic [IDXW-1:0]     hit_idx;

   for (genvar g = 0; g < N; g++) begin : g_ent
      logic [W-1:0] tag_q;
      logic [W-1:0] data_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_q  <= '0;
            data_q <= '0;
         end else if (wr_en && wr_idx == IDXW'(g)) begin
            tag_q  <= wr_tag;
            data_q <= wr_data;
         end
      end
      assign tag_arr[g]   = tag_q;
      assign data_arr[g]  = data_q;
      assign valid_vec[g] = data_q[VALID_BIT];
      assign lock_vec[g]  = data_q[LOCK_BIT];
      assign hit_vec[g]   = data_q[VALID_BIT] && (tag_q == srch_key);
   end

   tlbf_lowest_one #(.N(N)) u_hit (
      .vec   (hit_vec),
      .idx   (hit_idx),
      .found (srch_hit)
   );

   assign srch_tag = srch_hit ? tag_arr[hit_idx] : '0;
   assign rd_data  = data_arr[rd_idx];
endmodule

// File: rtl/tlbf_store.sv
module tlbf_store #(
   parameter int ENTRIES   = 64,
   parameter int W         = 64,
   parameter int ADDR_W    = 12,
   parameter int NREG      = 16,
   parameter int CREG_LSB  = 3,
   parameter int SLOT_LSB  = 3,
   parameter int VALID_BIT = 63,
   parameter int LOCK_BIT  = 6,
   parameter int TAG_REG   = 6,
   parameter int FSR_REG   = 3,
   parameter int FAR_REG   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [W-1:0]      req_wdata,
   output logic              rsp_valid,
   output logic [W-1:0]      rsp_data,
   output logic              fill_dropped
);
   import tlbf_pkg::*;

   localparam int IDXW = $clog2(ENTRIES);
   localparam int SELW = $clog2(NREG);

   if (ENTRIES != (1 << IDXW)) begin : g_chk_pow2
      $error("ENTRIES must be a power of two");
   end
   if (NREG != (1 << SELW)) begin : g_chk_nreg
      $error("NREG must be a power of two");
   end
   if (SLOT_LSB + IDXW > ADDR_W || CREG_LSB + SELW > ADDR_W) begin : g_chk_addr
      $error("address fields exceed ADDR_W");
   end
   if (VALID_BIT >= W || LOCK_BIT >= W || VALID_BIT == LOCK_BIT) begin : g_chk_bits
      $error("valid and lock bits must be distinct and inside W");
   end
   if (TAG_REG >= NREG || FSR_REG >= NREG || FAR_REG >= NREG) begin : g_chk_regs
      $error("special register index outside the bank");
   end

   logic [SELW-1:0]      creg_sel;
   logic [IDXW-1:0]      slot_sel;
   logic [NREG*W-1:0]    regs_flat;
   logic [W-1:0]         tag_stage;
   logic [W-1:0]         creg_rd;
   logic [ENTRIES-1:0]   valid_vec;
   logic [ENTRIES-1:0]   lock_vec;
   logic [IDXW-1:0]      inv_idx, unl_idx, fill_idx;
   logic                 inv_found, unl_found, fill_ok;
   logic                 ent_wr_en;
   logic [IDXW-1:0]      ent_wr_idx;
   logic [W-1:0]         slot_rd, srch_tag;
   logic                 srch_hit;
   logic                 is_creg_wr, is_fill, is_slot_wr;
   logic                 unused_addr_bits;

   assign creg_sel  = req_addr[CREG_LSB +: SELW];
   assign slot_sel  = req_addr[SLOT_LSB +: IDXW];
   assign unused_addr_bits = ^req_addr;

   assign is_creg_wr = req_valid && (req_op == OP_CREG_WR);
   assign is_fill    = req_valid && (req_op == OP_FILL);
   assign is_slot_wr = req_valid && (req_op == OP_SLOT_WR);

   tlbf_ctl_bank #(
      .NREG(NREG), .W(W), .FSR_REG(FSR_REG), .FAR_REG(FAR_REG), .CLR_BIT(0)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (is_creg_wr),
      .sel       (creg_sel),
      .wdata     (req_wdata),
      .regs_flat (regs_flat)
   );

   assign tag_stage = regs_flat[TAG_REG*W +: W];
   assign creg_rd   = regs_flat[creg_sel*W +: W];

   // Victim choice: invalid entries first, unlocked entries second.
   tlbf_lowest_one #(.N(ENTRIES)) u_inv (
      .vec   (~valid_vec),
      .idx   (inv_idx),
      .found (inv_found)
   );
   tlbf_lowest_one #(.N(ENTRIES)) u_unl (
      .vec   (~lock_vec),
      .idx   (unl_idx),
      .found (unl_found)
   );

   assign fill_ok    = inv_found || unl_found;
   assign fill_idx   = inv_found ? inv_idx : unl_idx;
   assign ent_wr_en  = (is_fill && fill_ok) || is_slot_wr;
   assign ent_wr_idx = is_fill ? fill_idx : slot_sel;

   tlbf_entry_array #(
      .N(ENTRIES), .W(W), .VALID_BIT(VALID_BIT), .LOCK_BIT(LOCK_BIT)
   ) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ent_wr_en),
      .wr_idx    (ent_wr_idx),
      .wr_tag    (tag_stage),
      .wr_data   (req_wdata),
      .rd_idx    (slot_sel),
      .srch_key  (req_wdata),
      .valid_vec (valid_vec),
      .lock_vec  (lock_vec),
      .rd_data   (slot_rd),
      .srch_tag  (srch_tag),
      .srch_hit  (srch_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_data     <= '0;
         fill_dropped <= 1'b0;
      end else begin
         rsp_valid    <= req_valid && op_is_read(req_op);
         fill_dropped <= is_fill && !fill_ok;
         if (req_valid) begin
            case (req_op)
               OP_CREG_RD:  rsp_data <= creg_rd;
               OP_TAG_SRCH: rsp_data <= srch_hit ? srch_tag : '0;
               OP_SLOT_RD:  rsp_data <= slot_rd;
               default:     rsp_data <= '0;
            endcase
         end else begin
            rsp_data <= '0;
         end
      end
   end
endmodule

// File: rtl/tlbf_store_chk.sv
module tlbf_store_chk #(
   parameter int ENTRIES   = 64,
   parameter int W         = 64,
   parameter int ADDR_W    = 12,
   parameter int NREG      = 16,
   parameter int CREG_LSB  = 3,
   parameter int VALID_BIT = 63,
   parameter int FSR_REG   = 3,
   parameter int FAR_REG   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [2:0]         req_op,
   input logic [ADDR_W-1:0]  req_addr,
   input logic [W-1:0]       req_wdata,
   input logic               rsp_valid,
   input logic               fill_dropped,
   input logic [ENTRIES-1:0] valid_vec,
   input logic [ENTRIES-1:0] lock_vec,
   input logic [NREG*W-1:0]  regs_flat
);
   import tlbf_pkg::*;
   localparam int SELW = $clog2(NREG);

   logic rd_req, fill_req, clr_req;
   assign rd_req   = req_valid && op_is_read(req_op);
   assign fill_req = req_valid && (req_op == OP_FILL);
   assign clr_req  = req_valid && (req_op == OP_CREG_WR)
                     && (req_addr[CREG_LSB +: SELW] == SELW'(FSR_REG)) && !req_wdata[0];

   AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (valid_vec == '0)); // R1
   AST_FILL_TAKES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && !(&valid_vec) && req_wdata[VALID_BIT]) |=>
         ($countones(valid_vec) == $past($countones(valid_vec)) + 1)); // R2
   AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      fill_dropped |-> $past(fill_req && (&valid_vec) && (&lock_vec))); // R4
   AST_DROP_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      fill_dropped |-> ($stable(valid_vec) && $stable(lock_vec))); // R4
   AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> ((regs_flat[FSR_REG*W +: W] == '0) && (regs_flat[FAR_REG*W +: W] == '0))); // R9
   AST_RSP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rsp_valid); // R10
   AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rsp_valid); // R10
endmodule

bind tlbf_store tlbf_store_chk #(
   .ENTRIES(ENTRIES), .W(W), .ADDR_W(ADDR_W), .NREG(NREG), .CREG_LSB(CREG_LSB),
   .VALID_BIT(VALID_BIT), .FSR_REG(FSR_REG), .FAR_REG(FAR_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_op       (req_op),
   .req_addr     (req_addr),
   .req_wdata    (req_wdata),
   .rsp_valid    (rsp_valid),
   .fill_dropped (fill_dropped),
   .valid_vec    (valid_vec),
   .lock_vec     (lock_vec),
   .regs_flat    (regs_flat)
);

// File: tb/tb_tlbf_store.sv
`timescale 1ns/1ps
module tb_tlbf_store;
   localparam logic [63:0] VB = 64'h8000_0000_0000_0000;
   localparam logic [63:0] LK = 64'h0000_0000_0000_0040;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = '0;
   logic [11:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic [63:0] rsp_data;
   logic        fill_dropped;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tlbf_store dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .fill_dropped(fill_dropped)
   );

   // op(3) addr(12) wdata(64) check(1) expect(64)
   localparam int NV = 15;
   localparam logic [143:0] TBL [NV] = '{
      {3'd1, 12'h008, 64'hAAAA_0000_0000_0001, 1'b0, 64'h0},
      {3'd0, 12'h008, 64'h0, 1'b1, 64'hAAAA_0000_0000_0001},
      {3'd1, 12'h010, 64'h0000_0000_0000_5555, 1'b0, 64'h0},
      {3'd0, 12'h010, 64'h0, 1'b1, 64'h0000_0000_0000_5555},
      {3'd0, 12'h008, 64'h0, 1'b1, 64'hAAAA_0000_0000_0001},
      {3'd1, 12'h018, 64'h0000_0000_0000_0081, 1'b0, 64'h0},
      {3'd1, 12'h020, 64'h0000_0000_DEAD_BEEF, 1'b0, 64'h0},
      {3'd0, 12'h018, 64'h0, 1'b1, 64'h0000_0000_0000_0081},
      {3'd0, 12'h020, 64'h0, 1'b1, 64'h0000_0000_DEAD_BEEF},
      {3'd1, 12'h018, 64'h0000_0000_0000_0080, 1'b0, 64'h0},
      {3'd0, 12'h018, 64'h0, 1'b1, 64'h0},
      {3'd0, 12'h020, 64'h0, 1'b1, 64'h0},
      {3'd0, 12'h008, 64'h0, 1'b1, 64'hAAAA_0000_0000_0001},
      {3'd1, 12'h0F8, 64'h0000_0000_0000_000F, 1'b0, 64'h0},
      {3'd0, 12'h078, 64'h0, 1'b1, 64'h0000_0000_0000_000F}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic op(input logic [2:0] o, input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_op = o; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_op = 3'd0; req_addr = '0; req_wdata = '0;
   endtask

   task automatic creg_wr(input int sel, input logic [63:0] d);
      op(3'd1, 12'(sel << 3), d);
   endtask
   task automatic slot_wr(input int idx, input logic [63:0] tag, input logic [63:0] d);
      creg_wr(6, tag);
      op(3'd3, 12'(idx << 3), d);
   endtask
   task automatic slot_rd(input int idx);
      op(3'd5, 12'(idx << 3), 64'h0);
   endtask
   task automatic fill(input logic [63:0] tag, input logic [63:0] d);
      creg_wr(6, tag);
      op(3'd2, 12'h0, d);
   endtask
   task automatic srch(input logic [63:0] key);
      op(3'd4, 12'h0, key);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rsp_valid", 64'(rsp_valid), 64'h0);
      check("R1 fill_dropped", 64'(fill_dropped), 64'h0);
      op(3'd0, 12'h030, 64'h0);
      check("R1 creg6", rsp_data, 64'h0);
      srch(64'h0);
      check("R1 R7 search on empty table", rsp_data, 64'h0);
      slot_rd(0);
      check("R1 slot0 data", rsp_data, 64'h0);

      // R8 R9 table of register vectors
      for (int i = 0; i < NV; i++) begin
         op(TBL[i][143:141], TBL[i][140:129], TBL[i][128:65]);
         if (TBL[i][64]) check("R8 R9 register vector", rsp_data, TBL[i][63:0]);
      end

      // R5 R6 R11 indexed write
      slot_wr(10, 64'h1111_0000_0000_000A, VB | 64'h10);
      check("R10 no response after write", 64'(rsp_valid), 64'h0);
      slot_rd(10);
      check("R6 R11 slot10 data", rsp_data, VB | 64'h10);
      check("R10 rsp_valid after read", 64'(rsp_valid), 64'h1);
      srch(64'h1111_0000_0000_000A);
      check("R5 R7 tag of slot10", rsp_data, 64'h1111_0000_0000_000A);

      // R2 fills go to lowest invalid
      fill(64'h2222_0000_0000_0001, VB | 64'h1);
      slot_rd(0);
      check("R2 first fill at slot0", rsp_data, VB | 64'h1);
      fill(64'h2222_0000_0000_0002, VB | 64'h2);
      slot_rd(1);
      check("R2 second fill at slot1", rsp_data, VB | 64'h2);
      srch(64'h2222_0000_0000_0002);
      check("R5 fill tag from creg6", rsp_data, 64'h2222_0000_0000_0002);

      // R7 invalid entry with matching tag is not returned
      slot_wr(2, 64'h3333_0000_0000_0000, LK);
      srch(64'h3333_0000_0000_0000);
      check("R7 invalid match returns zero", rsp_data, 64'h0);

      // fill table: all valid and locked
      for (int i = 0; i < 64; i++) slot_wr(i, 64'h1000 + 64'(i), VB | LK | 64'(i));
      slot_wr(40, 64'h4000, VB | 64'h28);
      slot_wr(50, 64'h5000, VB | 64'h32);

      // R3 lowest unlocked when all valid
      fill(64'h6000, VB | LK | 64'hD0);
      check("R3 fill not dropped", 64'(fill_dropped), 64'h0);
      slot_rd(40);
      check("R3 fill replaced slot40", rsp_data, VB | LK | 64'hD0);
      slot_rd(50);
      check("R3 slot50 untouched", rsp_data, VB | 64'h32);

      // R2 invalid beats unlocked even when the invalid entry has its lock bit set
      slot_wr(45, 64'h4500, LK);
      slot_wr(47, 64'h4700, 64'h0);
      fill(64'h7001, VB | LK | 64'hE1);
      slot_rd(45);
      check("R2 fill into invalid slot45", rsp_data, VB | LK | 64'hE1);
      slot_rd(50);
      check("R2 unlocked slot50 kept", rsp_data, VB | 64'h32);
      fill(64'h7002, VB | LK | 64'hE2);
      slot_rd(47);
      check("R2 fill into invalid slot47", rsp_data, VB | LK | 64'hE2);

      // R4 table full of locked entries
      slot_wr(50, 64'h5000, VB | LK | 64'h32);
      fill(64'h8888, VB | 64'hF0);
      check("R4 fill_dropped pulse", 64'(fill_dropped), 64'h1);
      srch(64'h8888);
      check("R4 dropped fill not stored", rsp_data, 64'h0);
      check("R4 pulse lasts one cycle", 64'(fill_dropped), 64'h0);
      slot_rd(63);
      check("R4 slot63 unchanged", rsp_data, VB | LK | 64'd63);

      // R10 unused op codes do nothing
      op(3'd7, 12'h1F8, 64'hFFFF);
      check("R10 op7 no response", 64'(rsp_valid), 64'h0);
      slot_rd(63);
      check("R10 op7 left slot63", rsp_data, VB | LK | 64'd63);

      // R1 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      srch(64'h1000 + 64'd63);
      check("R1 search after reset", rsp_data, 64'h0);
      slot_rd(50);
      check("R1 slot50 after reset", rsp_data, 64'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule